// File: doc/BRIEF.md
# Serial-Addressed One-Hot Line Selector

This block turns one of many memory gates on when it receives a serially transmitted line number followed by a commit pulse. The line number arrives on a single serial input, one bit per clock period, least significant bit first. A pulse on the input means 1 and no pulse means 0. A separate order input pulses for one period, in the period right after the last address bit. That pulse commits the collected number.

From the clock edge that samples the order pulse, exactly one output of a one-hot select vector goes high. It stays high for a fixed number of periods, by default one 32-period word time. After that all select outputs return low. A new order that arrives while a line is selected replaces the selection and restarts the hold time.

A shift register gathers the serial bits and a latch captures the address on the order pulse. A hold timer bounds how long the select is active, and a decoder expands the latched address into the select vector. The default width is 8 address bits, which gives 256 lines.

Top module: `serial_line_select`

## Requirements
- R1: While reset is high, and at the first sample after it, every select output is low. Reset also clears the collected address bits, so an order given with no bits sent after reset selects line 0.
- R2: The first serial bit received after the previous eight is bit 0 of the line number. The eighth is bit 7, the most significant bit. A high level on the serial input is a 1.
- R3: An order pulse selects the line whose number is made up of the eight serial bits sampled in the eight periods just before the order period.
- R4: The selected output is high in the period that follows the clock edge at which the order pulse is sampled. The latency is one period.
- R5: At most one select output is high in any period.
- R6: After an order, the chosen output stays high for exactly HOLD periods (32 by default). All select outputs are then low until the next order.
- R7: An order that arrives while a line is selected moves the select to the new line from the next period on. The HOLD periods restart from that order.
- R8: Serial bits received without an order pulse leave the select outputs unchanged. This holds whether no line or some line is selected.
- R9: Every line number from 0 to 255 can be selected, including both end values 0 and 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| addr_bit_i | input | 1 | Serial line-number bit, least significant first |
| order_i | input | 1 | Commit pulse, one period after the last address bit |
| sel_o | output | 2**ADDR_W | One-hot select vector, bit k drives gate k |

## Verification
An order pulse sampled at one rising edge must make its line visible at the falling edge that follows. The hold then covers exactly HOLD consecutive falling-edge samples, and the next sample must be all low. The bench drives every input at falling edges and samples at falling edges. Each check therefore sees the state that the latest rising edge produced, and it counts the high samples of the hold window one period at a time. For a replacement order, the old line is checked in the order period itself and the new line is checked one period later.

// File: rtl/sel_pkg.sv
package sel_pkg;

    localparam int unsigned DEF_ADDR_W = 8;
    localparam int unsigned DEF_HOLD   = 32;

    typedef enum logic {
        SEL_IDLE   = 1'b0,
        SEL_ACTIVE = 1'b1
    } sel_state_e;

    function automatic int unsigned count_width(input int unsigned n);
        int unsigned w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/sel_shift.sv
module sel_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sr_q;

    generate
        if (W == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= bit_i;
            end
        end else begin : g_multi
            // newest bit enters at the top, earliest ends at bit 0
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= {bit_i, sr_q[W-1:1]};
            end
        end
    endgenerate

    assign word_o = sr_q;
endmodule

// File: rtl/sel_latch.sv
module sel_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] addr_o
);
    logic [W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (load_i) addr_q <= word_i;
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/sel_hold.sv
module sel_hold
    import sel_pkg::*;
#(
    parameter int unsigned HOLD = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic active_o
);
    localparam int unsigned CW = count_width(HOLD);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD - 1);

    sel_state_e    state_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEL_IDLE;
            left_q  <= '0;
        end else if (load_i) begin
            state_q <= SEL_ACTIVE;
            left_q  <= LOAD_VAL;
        end else if (state_q == SEL_ACTIVE) begin
            if (left_q == '0) state_q <= SEL_IDLE;
            else              left_q  <= left_q - 1'b1;
        end
    end

    assign active_o = (state_q == SEL_ACTIVE);
endmodule

// File: rtl/sel_decode.sv
module sel_decode #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 256
) (
    input  logic [W-1:0] addr_i,
    input  logic         en_i,
    output logic [N-1:0] sel_o
);
    for (genvar k = 0; k < N; k++) begin : g_line
        assign sel_o[k] = en_i && (addr_i == W'(k));
    end
endmodule

// File: rtl/serial_line_select.sv
module serial_line_select
    import sel_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned HOLD   = DEF_HOLD,
    localparam int unsigned LINES = 1 << ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_bit_i,
    input  logic             order_i,
    output logic [LINES-1:0] sel_o
);
    logic [ADDR_W-1:0] gathered;
    logic [ADDR_W-1:0] held_addr;
    logic              active;

    sel_shift #(.W(ADDR_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (addr_bit_i),
        .word_o (gathered)
    );

    sel_latch #(.W(ADDR_W)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .load_i (order_i),
        .word_i (gathered),
        .addr_o (held_addr)
    );

    sel_hold #(.HOLD(HOLD)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load_i   (order_i),
        .active_o (active)
    );

    sel_decode #(.W(ADDR_W), .N(LINES)) u_decode (
        .addr_i (held_addr),
        .en_i   (active),
        .sel_o  (sel_o)
    );
endmodule

// File: rtl/serial_line_select_chk.sv
module serial_line_select_chk
    import sel_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned HOLD   = 32,
    localparam int unsigned LINES = 1 << ADDR_W,
    localparam int unsigned CW    = count_width(HOLD) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             addr_bit_i,
    input logic             order_i,
    input logic [LINES-1:0] sel_o
);
    logic [ADDR_W-1:0] shadow_q;
    logic [ADDR_W-1:0] want_q;
    logic [CW-1:0]     age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            want_q   <= '0;
            age_q    <= '0;
        end else begin
            shadow_q <= (ADDR_W == 1) ? ADDR_W'(addr_bit_i)
                                      : ADDR_W'({addr_bit_i, shadow_q} >> 1);
            if (order_i) begin
                want_q <= shadow_q;
                age_q  <= CW'(1);
            end else if (age_q != '0 && age_q != CW'(HOLD)) begin
                age_q <= age_q + 1'b1;
            end else begin
                age_q <= '0;
            end
        end
    end

    // R5
    one_hot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));

    // R4
    order_latency_chk: assert property (@(posedge clk) disable iff (rst)
        order_i |=> (sel_o != '0));

    // R3
    right_line_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != '0) |-> sel_o[want_q]);

    // R6
    hold_end_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == '0) |-> (sel_o == '0));

    // R8
    no_order_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!order_i && sel_o != '0) |=> (sel_o == '0 || $stable(sel_o)));
endmodule

bind serial_line_select serial_line_select_chk #(
    .ADDR_W (ADDR_W),
    .HOLD   (HOLD)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_bit_i (addr_bit_i),
    .order_i    (order_i),
    .sel_o      (sel_o)
);

// File: tb/serial_line_select_bench.sv
module serial_line_select_bench;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned HOLD   = 32;
    localparam int unsigned LINES  = 1 << ADDR_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             addr_bit_i = 1'b0;
    logic             order_i = 1'b0;
    logic [LINES-1:0] sel_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    serial_line_select #(.ADDR_W(ADDR_W), .HOLD(HOLD)) u_serial_line_select (
        .clk        (clk),
        .rst        (rst),
        .addr_bit_i (addr_bit_i),
        .order_i    (order_i),
        .sel_o      (sel_o)
    );

    always #5 clk = ~clk;

    // {address sent, expected line}
    localparam logic [15:0] VEC [10] = '{
        {8'h00, 8'd0},   {8'h01, 8'd1},   {8'h80, 8'd128}, {8'hFF, 8'd255},
        {8'hA5, 8'd165}, {8'h5A, 8'd90},  {8'h02, 8'd2},   {8'h40, 8'd64},
        {8'h7F, 8'd127}, {8'hFE, 8'd254}
    };

    function automatic logic [LINES-1:0] line_vec(input int line);
        return LINES'(1) << line;
    endfunction

    task automatic check_vec(input string req, input logic [LINES-1:0] got,
                             input logic [LINES-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] a);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            addr_bit_i = a[i];
            order_i    = 1'b0;
        end
    endtask

    // strobe in the period after the last bit; returns at the first sample
    task automatic strobe();
        @(negedge clk);
        addr_bit_i = 1'b0;
        order_i    = 1'b1;
        @(negedge clk);
        order_i    = 1'b0;
    endtask

    // counts samples (starting now) where only the given line is high
    task automatic measure_hold(input string req, input int line);
        int hi = 0;
        for (int i = 0; i < HOLD + 4; i++) begin
            if (sel_o === line_vec(line)) hi++;
            else if (sel_o !== '0) begin
                check_vec(req, sel_o, line_vec(line));
            end
            if (i != HOLD + 3) @(negedge clk);
        end
        check_int(req, hi, HOLD);
        check_vec(req, sel_o, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_vec("R1 reset", sel_o, '0);
        rst = 1'b0;
        @(negedge clk);
        check_vec("R1 after reset", sel_o, '0);

        // R1: order with no bits after reset selects line 0
        strobe();
        check_vec("R1 cleared shift", sel_o, line_vec(0));
        measure_hold("R6 hold after reset order", 0);

        // table: R2 R3 R4 R6 R9
        for (int v = 0; v < 10; v++) begin
            send_bits(VEC[v][15:8]);
            strobe();
            check_vec("R4 R3 R2 first sample", sel_o, line_vec(int'(VEC[v][7:0])));
            measure_hold("R6 hold length", int'(VEC[v][7:0]));
        end

        // random addresses, R3
        for (int r = 0; r < 6; r++) begin
            int a;
            a = int'($urandom_range(0, 255));
            send_bits(8'(a));
            strobe();
            check_vec("R3 random line", sel_o, line_vec(a));
            measure_hold("R6 random hold", a);
        end

        // R8: bits without order, idle
        send_bits(8'h3C);
        repeat (4) @(negedge clk);
        check_vec("R8 idle no order", sel_o, '0);

        // R7: replace while active; R8 during active
        send_bits(8'h11);
        strobe();
        check_vec("R7 first line", sel_o, line_vec(17));
        send_bits(8'hEE);
        check_vec("R8 bits while active", sel_o, line_vec(17));
        @(negedge clk);
        addr_bit_i = 1'b0;
        order_i    = 1'b1;
        check_vec("R7 old line in order period", sel_o, line_vec(17));
        @(negedge clk);
        order_i = 1'b0;
        check_vec("R7 new line next period", sel_o, line_vec(238));
        measure_hold("R7 hold restarted", 238);

        // R1: reset during hold
        send_bits(8'h99);
        strobe();
        check_vec("R1 before mid reset", sel_o, line_vec(153));
        rst = 1'b1;
        @(negedge clk);
        check_vec("R1 mid-hold reset", sel_o, '0);
        rst = 1'b0;
        @(negedge clk);
        check_vec("R1 stays low after reset", sel_o, '0);

        finish_run();
    end
endmodule